// File: doc/BRIEF.md
# Schedule-Driven Selective Trace Recorder

This block keeps an on-chip execution trace of a controller-plus-datapath circuit that runs at full clock rate. It does not sample a fixed group of signals every cycle. Instead it looks at the controller's current state and picks out only the datapath registers that the schedule writes in that state. Those values are packed into one trace word, which also carries the state tag and a count of filled value slots, and the word is written into a circular trace memory.

A mode input widens the capture so that memory read data is also recorded. Capture goes on until a stop input freezes the memory. After that, a valid/ready read port drains the stored words from the oldest to the newest. Back-pressure on this port is simple: `rd_valid` stays high and `rd_data` stays unchanged for as long as `rd_ready` is low, and a word is consumed only on a clock edge where both signals are high. A saturating counter reports how many words have been written since reset, so different capture policies can be compared by how much memory they use.

Top module: `sched_trace_rec`

## Requirements
- R1: Register selection follows the controller state. The register bank `dp_regs` holds register rk at bits [16k-1:16(k-1)].
  - State 1 records r1.
  - State 2 records r2 and r3.
  - State 5 records r6, r7, r8 and r9.
  - State 6 records r10.
  - Every other state records no register.
  - Selected values fill the slots in ascending register order, starting at slot 0.
- R2: A trace word is 71 bits wide:
  - bits [70:67] hold the 4-bit state tag;
  - bits [66:64] hold the number of filled slots (0 to 4);
  - slot j is at bits [16j+15:16j];
  - unfilled slots read as zero.
- R3: A cycle that selects no register and adds no memory read writes no word, and `wr_count` does not change.
- R4: Memory read capture works as follows:
  - When `memrd_mode` is 1 and `mem_rd_valid` is 1, `mem_rd_data` goes into the next free slot after the register values, even in a state that selects no register.
  - If all four slots are already taken, the read value is dropped and the count stays at 4.
  - When `memrd_mode` is 0, memory reads are ignored.
- R5: The trace memory holds DEPTH words. Once it is full, each new word overwrites the oldest one, so the memory keeps the last DEPTH words written.
- R6: On the clock edge where `stop` is sampled high, no word is written, even if the cycle has data to record. From that edge until reset, capture stays frozen and `wr_count` holds.
- R7: Readout order depends on whether the memory has wrapped:
  - If the memory never wrapped, readout starts at address 0 and returns exactly the words that were written.
  - If it wrapped, readout returns DEPTH words, starting with the oldest one still held.
- R8: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high and `rd_data` stays stable. A transfer happens only when both are high, and each transfer advances readout by one word.
- R9: `rd_done` goes high in the cycle after the last word has been taken, or straight after the freeze if nothing was recorded. While it is high, `rd_valid` is low.
- R10: `wr_count` counts the words written since reset and saturates at 2^CNT_W-1.
- R11: A synchronous reset clears the pointers, the wrap state, the freeze and `wr_count`. After reset, `rd_valid` and `rd_done` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_state | input | 4 | Current controller state |
| dp_regs | input | 160 | Ten 16-bit datapath registers, r1 in the low bits |
| mem_rd_valid | input | 1 | A memory read returns data this cycle |
| mem_rd_data | input | 16 | Memory read data |
| memrd_mode | input | 1 | Also record memory read data |
| stop | input | 1 | Freeze capture (sticky until reset) |
| rd_ready | input | 1 | Readout consumer ready |
| rd_valid | output | 1 | Readout word available |
| rd_data | output | 71 | Readout trace word |
| rd_done | output | 1 | All stored words have been read out |
| wr_count | output | CNT_W | Saturating count of words written |

## Verification
Capture takes one cycle. The inputs presented before a rising edge decide whether that edge writes a word, so `wr_count` is compared against the bench model at the falling edge that follows each driven cycle.

The freeze takes effect on the edge where `stop` is sampled. From the next falling edge the first word is on `rd_data`, because the read path from the memory is combinational. Each accepted word is compared at the falling edge where `rd_ready` is driven high. When a stall is chosen, the held word is compared again one cycle later.

`rd_done` is checked at the falling edge after the last transfer.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int STATE_W = 4;
  localparam int VAL_W   = 16;
  localparam int NREG    = 10;
  localparam int SLOTS   = 4;
  localparam int CW      = $clog2(SLOTS + 1);
  localparam int ENTRY_W = STATE_W + CW + SLOTS * VAL_W;

  // Registers written by the schedule in each controller state; bit k-1 is rk.
  function automatic logic [NREG-1:0] upd_mask(input logic [STATE_W-1:0] st);
    case (st)
      4'd1:    return 10'b00_0000_0001;
      4'd2:    return 10'b00_0000_0110;
      4'd5:    return 10'b01_1110_0000;
      4'd6:    return 10'b10_0000_0000;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/trc_select.sv
module trc_select
  import trc_pkg::*;
(
  input  logic [STATE_W-1:0]    state,
  input  logic [NREG*VAL_W-1:0] regs,
  input  logic                  mem_vld,
  input  logic [VAL_W-1:0]      mem_dat,
  input  logic                  mode,
  output logic [ENTRY_W-1:0]    entry,
  output logic                  has_entry
);
  logic [NREG-1:0]             mask;
  logic [CW-1:0]               cnt;
  logic [SLOTS-1:0][VAL_W-1:0] sl;

  always_comb begin
    mask = upd_mask(state);
    cnt  = '0;
    sl   = '0;
    for (int i = 0; i < NREG; i++) begin
      if (mask[i]) begin
        for (int j = 0; j < SLOTS; j++)
          if (cnt == CW'(j)) sl[j] = regs[i*VAL_W +: VAL_W];
        if (cnt != CW'(SLOTS)) cnt = cnt + 1'b1;
      end
    end
    if (mode && mem_vld) begin
      for (int j = 0; j < SLOTS; j++)
        if (cnt == CW'(j)) sl[j] = mem_dat;
      if (cnt != CW'(SLOTS)) cnt = cnt + 1'b1;
    end
    entry     = {state, cnt, sl};
    has_entry = (cnt != '0);
  end
endmodule

// File: rtl/trc_ring.sv
module trc_ring #(
  parameter int DEPTH = 64,
  parameter int EW    = 71
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [EW-1:0] wr_data,
  input  logic          stop,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic [EW-1:0] rd_data,
  output logic          rd_done,
  output logic          frozen,
  output logic          wrote
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int RW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [RW-1:0] remain;
  logic          wrapped;

  assign wrote    = wr_en && !frozen && !stop;
  assign rd_valid = frozen && (remain != '0);
  assign rd_done  = frozen && (remain == '0);
  assign rd_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wrote) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      remain  <= '0;
      wrapped <= 1'b0;
      frozen  <= 1'b0;
    end else begin
      if (wrote) begin
        wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
        if (wr_ptr == LAST) wrapped <= 1'b1;
      end
      if (stop && !frozen) begin
        frozen <= 1'b1;
        rd_ptr <= wrapped ? wr_ptr : '0;
        remain <= wrapped ? RW'(DEPTH) : RW'(wr_ptr);
      end else if (rd_valid && rd_ready) begin
        rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
        remain <= remain - 1'b1;
      end
    end
  end

  // R6
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    frozen |=> $stable(wr_ptr));
  // R8
  rd_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  // R9
  rd_last_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_ready && remain == RW'(1)) |=> rd_done);
  // R5
  wrap_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !$fell(wrapped));
endmodule

// File: rtl/sched_trace_rec.sv
module sched_trace_rec
  import trc_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [STATE_W-1:0]        ctl_state,
  input  logic [NREG*VAL_W-1:0]     dp_regs,
  input  logic                      mem_rd_valid,
  input  logic [VAL_W-1:0]          mem_rd_data,
  input  logic                      memrd_mode,
  input  logic                      stop,
  input  logic                      rd_ready,
  output logic                      rd_valid,
  output logic [ENTRY_W-1:0]        rd_data,
  output logic                      rd_done,
  output logic [CNT_W-1:0]          wr_count
);
  logic [ENTRY_W-1:0] entry;
  logic               has_entry, frozen, wrote;

  trc_select u_sel (
    .state(ctl_state), .regs(dp_regs), .mem_vld(mem_rd_valid),
    .mem_dat(mem_rd_data), .mode(memrd_mode),
    .entry(entry), .has_entry(has_entry)
  );

  trc_ring #(.DEPTH(DEPTH), .EW(ENTRY_W)) u_ring (
    .clk(clk), .rst(rst), .wr_en(has_entry), .wr_data(entry), .stop(stop),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_done(rd_done), .frozen(frozen), .wrote(wrote)
  );

  always_ff @(posedge clk) begin
    if (rst) wr_count <= '0;
    else if (wrote && wr_count != '1) wr_count <= wr_count + 1'b1;
  end

  // R6
  count_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    frozen |=> $stable(wr_count));
  // R10
  count_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_count == '1) |=> (wr_count == '1));
  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (wr_count == '0 && !rd_valid && !rd_done));
endmodule

// File: tb/sched_trace_rec_bench.sv
module sched_trace_rec_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int CNT_W = 8;
  localparam int EW = 71;

  logic clk = 0, rst = 1;
  logic [3:0] st = 0;
  logic [159:0] regs = 0;
  logic mv = 0, mode = 0, stop = 0, rdy = 0;
  logic [15:0] md = 0;
  logic rd_valid, rd_done;
  logic [EW-1:0] rd_data;
  logic [CNT_W-1:0] wr_count;

  int n_chk = 0, n_err = 0, tot = 0;
  bit frozen_m = 0;
  logic [EW-1:0] hist[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sched_trace_rec #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_sched_trace_rec (
    .clk(clk), .rst(rst), .ctl_state(st), .dp_regs(regs), .mem_rd_valid(mv),
    .mem_rd_data(md), .memrd_mode(mode), .stop(stop), .rd_ready(rdy),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_done(rd_done), .wr_count(wr_count));

  task automatic chk(bit ok, string req, logic [EW-1:0] act, logic [EW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [EW-1:0] exp_entry(logic [3:0] s, logic [159:0] r,
      logic v, logic [15:0] d, logic m, output bit has);
    logic [15:0] sv[4];
    int n = 0;
    int ids[$];
    for (int k = 0; k < 4; k++) sv[k] = 0;
    case (s)
      4'd1: ids = '{0};
      4'd2: ids = '{1, 2};
      4'd5: ids = '{5, 6, 7, 8};
      4'd6: ids = '{9};
      default: ids = '{};
    endcase
    foreach (ids[k]) begin sv[n] = r[ids[k]*16 +: 16]; n++; end
    if (m && v && n < 4) begin sv[n] = d; n++; end
    has = (n > 0);
    return {s, 3'(n), sv[3], sv[2], sv[1], sv[0]};
  endfunction

  function automatic int exp_cnt();
    return (tot > 255) ? 255 : tot;
  endfunction

  // one capture cycle with the currently driven inputs; R3 R10 count check
  task automatic cyc();
    bit has;
    logic [EW-1:0] e;
    e = exp_entry(st, regs, mv, md, mode, has);
    if (!frozen_m && !stop && has) begin hist.push_back(e); tot++; end
    if (stop) frozen_m = 1;
    @(posedge clk); @(negedge clk);
    chk(wr_count == CNT_W'(exp_cnt()), "R3/R10 wr_count", EW'(wr_count), EW'(exp_cnt()));
  endtask

  task automatic do_reset();
    rst = 1; stop = 0; rdy = 0; mv = 0; mode = 0; st = 0;
    repeat (3) begin @(posedge clk); @(negedge clk); end
    rst = 0;
    hist.delete(); tot = 0; frozen_m = 0;
    chk(!rd_valid && !rd_done && wr_count == 0, "R11 reset state",
        EW'({rd_valid, rd_done, wr_count}), '0);
  endtask

  task automatic rand_in(bit active);
    logic [3:0] pick[4] = '{4'd1, 4'd2, 4'd5, 4'd6};
    st   = active ? pick[$urandom % 4] : 4'($urandom);
    regs = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
    mv   = 1'($urandom);
    md   = 16'($urandom);
    mode = 1'($urandom);
  endtask

  task automatic freeze();
    st = 4'd1; regs = {5{32'hA5A5_1234}}; stop = 1;
    cyc();   // R6: data present but not written
    stop = 0;
    st = 4'd2; cyc();  // R6: still frozen
  endtask

  task automatic drain();
    int n = hist.size();
    int idx = (n > DEPTH) ? n - DEPTH : 0;
    bit stall = 0;
    logic [EW-1:0] held = 0;
    while (idx < n) begin
      if (stall) chk(rd_valid && rd_data == held, "R8 stall hold", rd_data, held);
      if (!rd_valid) begin chk(0, "R7 rd_valid missing", 0, 1); break; end
      rdy = ($urandom % 4) != 0;
      stall = !rdy; held = rd_data;
      if (rdy) begin
        chk(rd_data == hist[idx], "R1/R2/R5/R7 readout word", rd_data, hist[idx]);
        idx++;
      end
      @(posedge clk); @(negedge clk);
    end
    rdy = 0;
    chk(rd_done && !rd_valid, "R9 done after last", EW'({rd_done, rd_valid}), EW'(2'b10));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    do_reset();

    // random mix, no wrap: R1 R2 R3 R4 R7
    for (int i = 0; i < 40; i++) begin rand_in(0); cyc(); end
    freeze();
    drain();

    // directed R4 corners
    do_reset();
    regs = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
    st = 4'd5; mode = 1; mv = 1; md = 16'hBEEF; cyc();   // R4 read dropped, count 4
    st = 4'd3; cyc();                                      // R4 read-only word
    st = 4'd2; md = 16'h1357; cyc();                       // R4 read after regs
    st = 4'd3; mv = 0; cyc();                              // R3 nothing
    st = 4'd7; mode = 0; mv = 1; cyc();                    // R4 mode off ignored
    st = 4'd6; cyc();
    chk(hist[0][66:64] == 3'd4 && hist[1][15:0] == 16'hBEEF, "R4 model sanity",
        EW'(hist[0][66:64]), EW'(4));
    freeze();
    drain();

    // wrap and saturation: R5 R7 R10
    do_reset();
    for (int i = 0; i < 300; i++) begin rand_in(1); cyc(); end
    chk(wr_count == 8'd255, "R10 saturation", EW'(wr_count), EW'(255));
    freeze();
    drain();

    // empty freeze: R9
    do_reset();
    st = 4'd3; mode = 0; stop = 1; cyc(); stop = 0;
    chk(rd_done && !rd_valid, "R9 empty done", EW'({rd_done, rd_valid}), EW'(2'b10));

    // reset after freeze clears it: R11
    do_reset();
    st = 4'd1; cyc();
    chk(wr_count == 1, "R11 capture resumes", EW'(wr_count), EW'(1));

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule